// File: doc/BRIEF.md
# Programmable PWM Sound Generator

This block is the sound unit of a small 8-bit system. It runs from the system clock, nominally 6 MHz. A CPU configures it through a byte-wide register write port, and a combinational read port returns configuration and live counter state. The block drives two digital speaker pins in push-pull.

Two tone channels are built from 12-bit up-counters that reload at their top value. One of them can be swapped for a 15-bit LFSR noise source. A 32-slot volume gate interleaves the two channels and sets their loudness. For sampled sound the block also has a 7-bit PWM engine. In single-ended mode both pins carry complementary copies of the waveform. In double-ended mode the sign of an 8-bit sample chooses which pin pulses, which gives one extra bit of amplitude. A programmable PWM prescaler and a sample counter produce a periodic one-cycle sample interrupt that the CPU uses to feed new samples. In tone mode the interrupt follows the second tone channel.

Top module: `psg_top`

## Requirements
- R1: After synchronous active-low reset, both speaker pins are high, `irq` is low, and the control register (address 5) reads 80h: mode 0, prescaler code 0, bit 7 always 1.
- R2: Each tone counter advances once per audio tick. When it holds FFFh it loads its 12-bit reload value and emits a tick. Every two ticks the tone level inverts, so a full period is four ticks at 50% duty. Tone A's reload is {addr1[3:0], addr0}. Tone B's reload is {addr3[3:0], addr2}.
- R3: The prescaler code in control bits [6:4] sets the audio tick rate. Codes 0, 1, 2 and 3 tick every 1, 2, 4 and 6 clocks. Codes 4 to 6 tick every clock. Code 7 ticks on each `rtcTick` pulse.
- R4: Reading address 0 or 2 returns the low byte of the live count of tone A or tone B. Reading address 1 or 3 returns 1111b above the upper four count bits. Address 7 reads FFh.
- R5: Noise modes (Ch, Eh) use a 15-bit LFSR that resets to all ones. On each tone-B tick it shifts left, and bit 14 XOR bit 13 enters bit 0. Bit 14 is the noise level.
- R6: In mode Dh (double-ended PWM) with sample s, a non-negative s holds `spkN` high and drives `spkP` low for s of every 128 phase steps. A negative s holds `spkP` high and drives `spkN` low for -s steps. The sample is at address 4.
- R7: In mode 1 (single-ended PWM), `spkP` is high for ((s[6:0]+40h) mod 128) of every 128 phase steps and `spkN` is its complement. So 00h gives 50%, 3Fh gives 127/128, and C0h gives 0.
- R8: The PWM phase advances when a 6-bit prescaler at FFh... more precisely, when a 6-bit prescaler holding 3Fh reloads from addr2[5:0]. A reload of 3Fh steps the phase every clock and 3Eh every second clock.
- R9: In PWM modes a 6-bit sample counter advances once per 128-step phase wrap. At 3Fh it reloads {addr3[3:0], addr2[7:6]} and raises `irq` for exactly one cycle. A reload of 3Ah gives one pulse per 6 samples.
- R10: In modes 4 and 6, `irq` pulses once on every tone-B level change. Noise modes never raise `irq`.
- R11: Volume codes are at address 6, channel 1 in bits [3:0] and channel 2 in bits [7:4]. Over 32 clocks, even slots belong to channel 1 and odd slots to channel 2. A code v opens v of its 16 slots for v below Fh, and all 16 for Fh. In tone modes `spkP` stays high and `spkN` is low while an open slot's channel level is high.
- R12: The mode is in control bits [3:0]. Modes 2 (A/A), 4 (B/B), 6 (A/B), Ch (noise/noise) and Eh (A/noise) are tone modes, listing channel 1 then channel 2 sources. Modes 1 and Dh are PWM modes. Every other mode holds both pins high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| rtcTick | input | 1 | One-cycle pulse from the low-frequency timebase, used by prescaler code 7 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Read data for `rdAddr` (combinational) |
| spkP | output | 1 | First speaker pin |
| spkN | output | 1 | Second speaker pin |
| irq | output | 1 | Sample or tone interrupt pulse |

## Verification
Some properties are checked on every clock: silent modes keep both pins high, tone modes keep `spkP` high, double-ended PWM never pulls both pins low at once, noise modes never raise `irq`, and `irq` never lasts more than one cycle. Other behaviour only shows up in the bench scenarios because it lives in counts over many cycles. These are the tone half-periods under each prescaler code, PWM duty per sample value, interrupt spacing, volume slot totals, and the LFSR's XOR recurrence on the pin.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int TONE_W  = 12;
  localparam int LFSR_W  = 15;
  localparam int PHASE_W = 7;
  localparam int SCNT_W  = 6;
  localparam int VOL_W   = 4;
  localparam int SLOT_W  = 5;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;

  typedef enum logic [1:0] {
    KIND_SILENT,
    KIND_TONE,
    KIND_PWM_SE,
    KIND_PWM_DE
  } kind_e;

  typedef struct packed {
    logic  audTick;
    logic  pwmStep;
    kind_e kind;
    logic  ch1FromB;
    logic  ch2FromB;
    logic  noiseOn;
    logic  irqOnToggle;
    logic  irqOnSample;
  } strobe_t;

  typedef struct packed {
    logic [TONE_W-1:0] reloadA;
    logic [TONE_W-1:0] reloadB;
    logic [SCNT_W-1:0] sampReload;
    logic [DATA_W-1:0] sample;
    logic [VOL_W-1:0]  vol1;
    logic [VOL_W-1:0]  vol2;
  } cfg_t;
endpackage

// File: rtl/psg_ctrl.sv
module psg_ctrl
  import psg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [TONE_W-1:0] cntA,
  input  logic [TONE_W-1:0] cntB,
  output cfg_t              cfg,
  output strobe_t           stb,
  output logic [3:0]        mode
);
  localparam int HI_W   = TONE_W - DATA_W;
  localparam int PRE_W  = SCNT_W;

  logic [TONE_W-1:0] reloadAQ;
  logic [DATA_W-1:0] freqBLoQ;
  logic [HI_W-1:0]   freqBHiQ;
  logic [DATA_W-1:0] sampleQ;
  logic [6:0]        ctrlQ;
  logic [DATA_W-1:0] volQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadAQ <= '0;
      freqBLoQ <= '0;
      freqBHiQ <= '0;
      sampleQ  <= '0;
      ctrlQ    <= '0;
      volQ     <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        3'd0: reloadAQ[DATA_W-1:0]      <= wrData;
        3'd1: reloadAQ[TONE_W-1:DATA_W] <= wrData[HI_W-1:0];
        3'd2: freqBLoQ <= wrData;
        3'd3: freqBHiQ <= wrData[HI_W-1:0];
        3'd4: sampleQ  <= wrData;
        3'd5: ctrlQ    <= wrData[6:0];
        3'd6: volQ     <= wrData;
        default: ;
      endcase
    end
  end

  assign mode = ctrlQ[3:0];
  logic [2:0] presc;
  assign presc = ctrlQ[6:4];

  always_comb begin
    cfg.reloadA    = reloadAQ;
    cfg.reloadB    = {freqBHiQ, freqBLoQ};
    cfg.sampReload = {freqBHiQ, freqBLoQ[DATA_W-1:PRE_W]};
    cfg.sample     = sampleQ;
    cfg.vol1       = volQ[VOL_W-1:0];
    cfg.vol2       = volQ[DATA_W-1:VOL_W];
  end

  always_comb begin
    case (rdAddr)
      3'd0:    rdData = cntA[DATA_W-1:0];
      3'd1:    rdData = {{(DATA_W-HI_W){1'b1}}, cntA[TONE_W-1:DATA_W]};
      3'd2:    rdData = cntB[DATA_W-1:0];
      3'd3:    rdData = {{(DATA_W-HI_W){1'b1}}, cntB[TONE_W-1:DATA_W]};
      3'd4:    rdData = sampleQ;
      3'd5:    rdData = {1'b1, ctrlQ};
      3'd6:    rdData = volQ;
      default: rdData = '1;
    endcase
  end

  // Audio clock prescaler
  logic [2:0] divCnt, divLast;
  always_comb begin
    case (presc)
      3'd1:    divLast = 3'd1;
      3'd2:    divLast = 3'd3;
      3'd3:    divLast = 3'd5;
      default: divLast = 3'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 divCnt <= '0;
    else if (divCnt >= divLast) divCnt <= '0;
    else                       divCnt <= divCnt + 3'd1;
  end

  // PWM prescaler: counts up, reloads at all ones
  logic [PRE_W-1:0] pwmPre;
  logic             pwmStep;
  assign pwmStep = (pwmPre == '1);
  always_ff @(posedge clk) begin
    if (!rstN)        pwmPre <= '0;
    else if (pwmStep) pwmPre <= freqBLoQ[PRE_W-1:0];
    else              pwmPre <= pwmPre + 1'b1;
  end

  always_comb begin
    stb             = '0;
    stb.audTick     = (presc == 3'd7) ? rtcTick : (divCnt == divLast);
    stb.pwmStep     = pwmStep;
    stb.kind        = KIND_SILENT;
    case (mode)
      4'h1: begin stb.kind = KIND_PWM_SE; stb.irqOnSample = 1'b1; end
      4'hD: begin stb.kind = KIND_PWM_DE; stb.irqOnSample = 1'b1; end
      4'h2: stb.kind = KIND_TONE;
      4'h4: begin
        stb.kind = KIND_TONE; stb.ch1FromB = 1'b1; stb.ch2FromB = 1'b1; stb.irqOnToggle = 1'b1;
      end
      4'h6: begin stb.kind = KIND_TONE; stb.ch2FromB = 1'b1; stb.irqOnToggle = 1'b1; end
      4'hC: begin
        stb.kind = KIND_TONE; stb.ch1FromB = 1'b1; stb.ch2FromB = 1'b1; stb.noiseOn = 1'b1;
      end
      4'hE: begin stb.kind = KIND_TONE; stb.ch2FromB = 1'b1; stb.noiseOn = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/psg_datapath.sv
module psg_datapath
  import psg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  strobe_t           stb,
  output logic [TONE_W-1:0] cntA,
  output logic [TONE_W-1:0] cntB,
  output logic              spkP,
  output logic              spkN,
  output logic              irq
);
  localparam int NUM_TONE = 2;

  logic [NUM_TONE-1:0] level, tick, toggle;

  for (genvar g = 0; g < NUM_TONE; g++) begin : g_tone
    logic [TONE_W-1:0] toneCnt;
    logic [1:0]        quarter;
    logic [TONE_W-1:0] reloadVal;
    assign reloadVal = (g == 0) ? cfg.reloadA : cfg.reloadB;
    assign tick[g]   = stb.audTick && (toneCnt == '1);
    assign level[g]  = ~quarter[1];
    assign toggle[g] = tick[g] && quarter[0];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        toneCnt <= '0;
        quarter <= '0;
      end else if (stb.audTick) begin
        if (toneCnt == '1) begin
          toneCnt <= reloadVal;
          quarter <= quarter + 2'd1;
        end else begin
          toneCnt <= toneCnt + 1'b1;
        end
      end
    end
  end

  assign cntA = g_tone[0].toneCnt;
  assign cntB = g_tone[1].toneCnt;

  // Noise source
  logic [LFSR_W-1:0] lfsr;
  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= '1;
    else if (stb.noiseOn && tick[1])
      lfsr <= {lfsr[LFSR_W-2:0], lfsr[LFSR_W-1] ^ lfsr[LFSR_W-2]};
  end

  // PWM phase and sample counter
  logic [PHASE_W-1:0] phase;
  logic [SCNT_W-1:0]  sampCnt;
  logic               wrap, sampFire;
  assign wrap     = stb.pwmStep && (phase == '1);
  assign sampFire = wrap && (sampCnt == '1);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      sampCnt <= '0;
    end else begin
      if (stb.pwmStep) phase <= phase + 1'b1;
      if (wrap) sampCnt <= sampFire ? cfg.sampReload : sampCnt + 1'b1;
    end
  end

  // Volume gate
  logic [SLOT_W-1:0] slot;
  logic [VOL_W-1:0]  step;
  logic              gate1, gate2;
  assign step  = slot[SLOT_W-1:1];
  assign gate1 = (cfg.vol1 == '1) || (step < cfg.vol1);
  assign gate2 = (cfg.vol2 == '1) || (step < cfg.vol2);
  always_ff @(posedge clk) begin
    if (!rstN) slot <= '0;
    else       slot <= slot + 1'b1;
  end

  logic srcB, ch1, ch2, active;
  assign srcB   = stb.noiseOn ? lfsr[LFSR_W-1] : level[1];
  assign ch1    = stb.ch1FromB ? srcB : level[0];
  assign ch2    = stb.ch2FromB ? srcB : level[0];
  assign active = slot[0] ? (ch2 & gate2) : (ch1 & gate1);

  logic [PHASE_W-1:0] thrSe;
  logic [DATA_W-1:0]  mag;
  logic               seHigh, dePulse;
  assign thrSe   = cfg.sample[PHASE_W-1:0] + PHASE_W'(1 << (PHASE_W-1));
  assign seHigh  = phase < thrSe;
  assign mag     = cfg.sample[DATA_W-1] ? (DATA_W'(0) - cfg.sample) : cfg.sample;
  assign dePulse = {1'b0, phase} < mag;

  logic nextP, nextN;
  always_comb begin
    nextP = 1'b1;
    nextN = 1'b1;
    case (stb.kind)
      KIND_TONE:   nextN = ~active;
      KIND_PWM_SE: begin nextP = seHigh; nextN = ~seHigh; end
      KIND_PWM_DE: begin
        if (cfg.sample[DATA_W-1]) nextN = ~dePulse;
        else                      nextP = ~dePulse;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spkP <= 1'b1;
      spkN <= 1'b1;
      irq  <= 1'b0;
    end else begin
      spkP <= nextP;
      spkN <= nextN;
      irq  <= (stb.irqOnSample && sampFire) || (stb.irqOnToggle && toggle[1]);
    end
  end
endmodule

// File: rtl/psg_top.sv
module psg_top
  import psg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              spkP,
  output logic              spkN,
  output logic              irq
);
  cfg_t              cfg;
  strobe_t           stb;
  logic [3:0]        mode;
  logic [TONE_W-1:0] cntA, cntB;

  psg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rtcTick(rtcTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .cntA(cntA), .cntB(cntB),
    .cfg(cfg), .stb(stb), .mode(mode)
  );

  psg_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb),
    .cntA(cntA), .cntB(cntB),
    .spkP(spkP), .spkN(spkN), .irq(irq)
  );
endmodule

// File: rtl/psg_chk.sv
module psg_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] mode,
  input logic       spkP,
  input logic       spkN,
  input logic       irq
);
  logic isPwm, isTone, isNoise, isSilent;
  assign isPwm    = (mode == 4'h1) || (mode == 4'hD);
  assign isTone   = (mode == 4'h2) || (mode == 4'h4) || (mode == 4'h6) ||
                    (mode == 4'hC) || (mode == 4'hE);
  assign isNoise  = (mode == 4'hC) || (mode == 4'hE);
  assign isSilent = !isPwm && !isTone;

  // R12: unimplemented modes leave both pins high
  assert_silent_R12: assert property (@(posedge clk) disable iff (!rstN)
    isSilent |=> (spkP && spkN));

  // R12: tone modes hold the first pin high
  assert_tone_p_high_R12: assert property (@(posedge clk) disable iff (!rstN)
    isTone |=> spkP);

  // R6: double-ended PWM never pulls both pins low together
  assert_de_one_side_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'hD) |=> (spkP || spkN));

  // R10: noise modes raise no interrupt
  assert_noise_no_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    isNoise |=> !irq);

  // R9: interrupt is a single-cycle pulse
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
endmodule

bind psg_top psg_chk u_chk (
  .clk(clk), .rstN(rstN), .mode(mode),
  .spkP(spkP), .spkN(spkN), .irq(irq)
);

// File: tb/psg_top_tb.sv
module psg_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rtcTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       spkP, spkN, irq;
  logic       rtcEn = 1'b0;
  bit         finished = 1'b0;

  int vectors = 0;
  int miscompares = 0;

  typedef struct {
    string req;
    int    val;
  } item_t;
  item_t expQ[$];
  int    actQ[$];

  always #4 clk = ~clk;

  psg_top u_dut (
    .clk(clk), .rstN(rstN), .rtcTick(rtcTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .spkP(spkP), .spkN(spkN), .irq(irq)
  );

  // Low-frequency timebase: one pulse every 10 clocks when enabled
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c == 9) ? 0 : c + 1;
      rtcTick = rtcEn && (c == 9);
    end
  end

  // Monitor: pops expected and actual items and compares them
  initial begin
    forever begin
      @(negedge clk);
      while (actQ.size() > 0 && expQ.size() > 0) begin
        item_t e;
        int    a;
        e = expQ.pop_front();
        a = actQ.pop_front();
        vectors++;
        if (a != e.val) begin
          miscompares++;
          $display("FAIL %s: actual %0d expected %0d", e.req, a, e.val);
        end
      end
    end
  end

  task automatic expectItem(input string req, input int e);
    expQ.push_back('{req, e});
  endtask

  task automatic observe(input int a);
    actQ.push_back(a);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic countLow(input int n, output int lp, output int ln);
    lp = 0; ln = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!spkP) lp++;
      if (!spkN) ln++;
    end
  endtask

  task automatic halfPeriod(output int h);
    logic v;
    int   guard = 0;
    @(negedge clk);
    v = spkN;
    while (spkN == v && guard < 5000) begin @(negedge clk); guard++; end
    v = spkN;
    h = 0;
    do begin @(negedge clk); h++; end while (spkN == v && h < 5000);
  endtask

  task automatic irqGap(output int g);
    int guard = 0;
    @(negedge clk);
    while (!irq && guard < 20000) begin @(negedge clk); guard++; end
    g = 0;
    do begin @(negedge clk); g++; end while (!irq && g < 5000);
  endtask

  task automatic checkPwm(input string req, input logic [7:0] s, input int n,
                          input int expP, input int expN);
    int lp, ln;
    wr(3'd4, s);
    tick(4);
    countLow(n, lp, ln);
    expectItem(req, expP); observe(lp);
    expectItem(req, expN); observe(ln);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int lp, ln, h, g;
    int bits[200];
    int bad, trans;

    doReset();

    // R1: reset state
    tick(1);
    rdAddr = 3'd5;
    tick(1);
    expectItem("R1 spkP", 1); observe(int'(spkP));
    expectItem("R1 spkN", 1); observe(int'(spkN));
    expectItem("R1 irq", 0);  observe(int'(irq));
    expectItem("R1 ctrl", 8'h80); observe(int'(rdData));
    rdAddr = 3'd7;
    tick(1);
    expectItem("R4 unused addr", 8'hFF); observe(int'(rdData));

    // R12: mode 0 is silent
    countLow(64, lp, ln);
    expectItem("R12 mode0", 0); observe(lp + ln);

    // R11: volume slots, tone A level high right after reset
    wr(3'd5, 8'h02);
    wr(3'd6, 8'h53);
    tick(4);
    countLow(32, lp, ln);
    expectItem("R11 vol 3/5", 8); observe(ln);
    expectItem("R11 spkP high", 0); observe(lp);
    wr(3'd6, 8'hEF); tick(4); countLow(32, lp, ln);
    expectItem("R11 vol F/E", 30); observe(ln);
    wr(3'd6, 8'h00); tick(4); countLow(32, lp, ln);
    expectItem("R11 vol 0/0", 0); observe(ln);
    wr(3'd6, 8'hF1); tick(4); countLow(32, lp, ln);
    expectItem("R11 vol 1/F", 17); observe(ln);

    // R2: tone period with reload FEDh: 19 ticks per overflow, 38 per half
    wr(3'd0, 8'hED);
    wr(3'd1, 8'h0F);
    wr(3'd6, 8'hFF);
    tick(4300);
    halfPeriod(h); expectItem("R2 half period", 38); observe(h);
    halfPeriod(h); expectItem("R2 half period", 38); observe(h);

    // R4: live counter readback
    rdAddr = 3'd1; tick(1);
    expectItem("R4 cntA high", 8'hFF); observe(int'(rdData));
    rdAddr = 3'd0; tick(1);
    expectItem("R4 cntA low in range", 1); observe(int'(rdData >= 8'hED));
    rdAddr = 3'd3; tick(1);
    expectItem("R4 cntB upper ones", 4'hF); observe(int'(rdData[7:4]));

    // R3: prescaler codes
    wr(3'd5, 8'h32); tick(500);
    halfPeriod(h); expectItem("R3 div6", 228); observe(h);
    wr(3'd5, 8'h12); tick(200);
    halfPeriod(h); expectItem("R3 div2", 76); observe(h);
    wr(3'd5, 8'h22); tick(300);
    halfPeriod(h); expectItem("R3 div4", 152); observe(h);
    wr(3'd5, 8'h42); tick(100);
    halfPeriod(h); expectItem("R3 code4", 38); observe(h);
    rtcEn = 1'b1;
    wr(3'd5, 8'h72); tick(1000);
    halfPeriod(h); expectItem("R3 rtc", 380); observe(h);
    rtcEn = 1'b0;

    // R10: tone-mode interrupt on tone B toggle
    doReset();
    wr(3'd5, 8'h04);
    wr(3'd2, 8'hED);
    wr(3'd3, 8'h0F);
    tick(4300);
    irqGap(g); expectItem("R10 tone irq gap", 38); observe(g);

    // R9: sample interrupt, prescaler 3Fh, sample reload 3Ah
    wr(3'd5, 8'h0D);
    wr(3'd2, 8'hBF);
    wr(3'd3, 8'h0E);
    irqGap(g);
    irqGap(g); expectItem("R9 sample irq gap", 768); observe(g);
    tick(1);
    expectItem("R9 pulse width", 0); observe(int'(irq));

    // R6: double-ended duty
    checkPwm("R6 40h", 8'h40, 128, 64, 0);
    checkPwm("R6 7Fh", 8'h7F, 128, 127, 0);
    checkPwm("R6 C0h", 8'hC0, 128, 0, 64);
    checkPwm("R6 80h", 8'h80, 128, 0, 128);
    checkPwm("R6 00h", 8'h00, 128, 0, 0);

    // R8: prescaler reload 3Eh doubles the period
    wr(3'd2, 8'hBE);
    checkPwm("R8 presc 3Eh", 8'h40, 256, 128, 0);
    irqGap(g); expectItem("R8 R9 irq gap at 3Eh", 1536); observe(g);
    wr(3'd2, 8'hBF);

    // R7: single-ended
    wr(3'd5, 8'h01);
    checkPwm("R7 00h", 8'h00, 128, 64, 64);
    checkPwm("R7 3Fh", 8'h3F, 128, 1, 127);
    checkPwm("R7 C0h", 8'hC0, 128, 128, 0);

    // R12: other unimplemented modes
    wr(3'd5, 8'h03); tick(4); countLow(64, lp, ln);
    expectItem("R12 mode3", 0); observe(lp + ln);
    wr(3'd5, 8'h09); tick(4); countLow(64, lp, ln);
    expectItem("R12 mode9", 0); observe(lp + ln);

    // R5: noise, LFSR all ones held until tone B first overflows
    doReset();
    wr(3'd5, 8'h0C);
    wr(3'd6, 8'hFF);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'h0F);
    countLow(3900, lp, ln);
    expectItem("R5 reset all ones", 3900); observe(ln);
    g = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (irq) g++;
    end
    expectItem("R10 noise no irq", 0); observe(g);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      bits[i] = spkN ? 0 : 1;
    end
    bad = 0; trans = 0;
    for (int i = 0; i + 15 < 200; i++)
      if (bits[i + 15] != (bits[i] ^ bits[i + 1])) bad++;
    for (int i = 0; i + 1 < 200; i++)
      if (bits[i] != bits[i + 1]) trans++;
    expectItem("R5 recurrence", 0); observe(bad);
    expectItem("R5 sequence moves", 1); observe(int'(trans > 10));

    tick(3);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule